// File: doc/BRIEF.md
# Asynchronous Link Register Bridge

This block gives a host running on the system clock read and write access to a small bank of 32-bit link-layer registers clocked by an unrelated link clock. The host sees four words in a simple memory-mapped slave. It starts a remote access by writing a byte address into one of two address words, then polls a completion flag. When a read completes, the fetched value sits in the data word.

A request crosses the clock boundary as a toggle, and a second toggle returns as the acknowledge. Each direction passes through a two-flop synchroniser. While the toggle is in flight, the host side holds the address, data and direction steady. The link side samples them only after the synchronised request edge.

The remote bank holds these registers:
- a read-only status register that reflects a link-domain input;
- a latched error register, cleared by writing ones to it;
- read/write control, active and notification registers;
- two vendor settings registers, for transmit level and attenuation.

The read/write registers drive link-domain outputs.

Top module: `link_reg_bridge`

## Requirements
- R1: After reset the host data word and the control word read 0, and every remote register and link output is 0.
- R2: Host word offsets are fixed: 28 data, 29 read-address, 30 write-address, 31 control (bit 0 = done). Offsets 29 and 30 read as 0. Every other offset reads 0, and writes to it are discarded.
- R3: Writing a byte address to offset 29 starts a remote read. On completion the data word holds the remote register's value.
- R4: Writing a byte address to offset 30 starts a remote write of the current data word into that remote register.
- R5: Done (control bit 0) goes to 0 in the cycle after a transfer starts, and it goes to 1 once that transfer's acknowledge has returned.
- R6: While a transfer is outstanding, host writes to offsets 28, 29 and 30 are ignored. Ignored address writes start no transfer.
- R7: The remote bank uses byte addresses, and address bits [1:0] are ignored. The map is: 0x20 status (read-only, mirrors lnk_status_i), 0x24 error, 0x28 control, 0x2C active, 0x30 notification, 0x60 transmit level, 0x70 transmit attenuation. Unmapped addresses read 0, and writes to them are discarded.
- R8: Error bits latch when lnk_err_set_i is high in a link cycle. Writing 1 to an error bit clears it, and a set in the same cycle wins. Writing all ones clears every latched bit.
- R9: Each request performs exactly one remote access, through a request/acknowledge toggle pair, each side with two synchroniser flops. Completion therefore takes several cycles of both clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Host asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 5 | Host word offset |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data (combinational from host_addr_i) |
| lnk_clk_i | input | 1 | Link clock |
| lnk_rst_ni | input | 1 | Link asynchronous reset, active low |
| lnk_status_i | input | 32 | Live status value shown at 0x20 |
| lnk_err_set_i | input | 32 | Per-bit error set pulses |
| lnk_ctrl_o | output | 32 | Control register contents |
| lnk_active_o | output | 32 | Active register contents |
| lnk_notify_o | output | 32 | Notification register contents |
| lnk_tx_lvl_o | output | 32 | Transmit level setting |
| lnk_tx_att_o | output | 32 | Transmit attenuation setting |

## Verification
The bench issues host writes that arrive while a transfer is still in flight: a second data write and a second address write. A bridge that let either through would overwrite the outgoing value or launch a second access, which would show up as a wrong control value or a changed attenuation register. It reads done directly after an address write. A bridge that kept a stale done flag would let polling software read data before it arrives. It also checks several cases at the ports:
- the status register keeps mirroring its input after a write to it, catching a bridge that stores the write;
- an unmapped address reads 0, catching a wrongly decoded write;
- a partial write-one clear of the error register leaves the uncleared error bit set;
- completion takes no fewer cycles than the two synchroniser pairs require.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
  localparam int unsigned HOFS_DATA  = 28;
  localparam int unsigned HOFS_RADDR = 29;
  localparam int unsigned HOFS_WADDR = 30;
  localparam int unsigned HOFS_CTRL  = 31;

  localparam int unsigned STD_BASE    = 'h20;
  localparam int unsigned STD_STATUS  = 0;
  localparam int unsigned STD_ERROR   = 1;
  localparam int unsigned STD_CONTROL = 2;
  localparam int unsigned STD_ACTIVE  = 3;
  localparam int unsigned STD_NOTIFY  = 4;
  localparam int unsigned VND_TXLVL   = 'h60;
  localparam int unsigned VND_TXATT   = 'h70;

  // plain read/write registers in the remote bank
  localparam int unsigned RW_NUM = 5;

  function automatic int unsigned std_byte(int unsigned i);
    return STD_BASE + 4 * i;
  endfunction

  function automatic int unsigned rw_byte(int unsigned k);
    case (k)
      0:       return std_byte(STD_CONTROL);
      1:       return std_byte(STD_ACTIVE);
      2:       return std_byte(STD_NOTIFY);
      3:       return VND_TXLVL;
      default: return VND_TXATT;
    endcase
  endfunction
endpackage

// File: rtl/lrb_sync.sv
module lrb_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/lrb_host_port.sv
module lrb_host_port import lrb_pkg::*; #(
  parameter int unsigned DW      = 32,
  parameter int unsigned HOST_AW = 5,
  parameter int unsigned LNK_AW  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic               ack_tgl_i,
  input  logic [DW-1:0]      lnk_rdata_i,
  output logic               req_tgl_o,
  output logic [LNK_AW-1:0]  xfer_addr_o,
  output logic [DW-1:0]      xfer_wdata_o,
  output logic               xfer_rnw_o
);
  logic              req_q, ack_q, done_q, rnw_q;
  logic [LNK_AW-1:0] addr_q;
  logic [DW-1:0]     data_q;
  logic              busy, ack_edge, start_rd, start_wr, wr_data;

  assign busy     = req_q ^ ack_q;
  assign ack_edge = ack_tgl_i ^ ack_q;
  assign start_rd = we_i && !busy && (addr_i == HOST_AW'(HOFS_RADDR));
  assign start_wr = we_i && !busy && (addr_i == HOST_AW'(HOFS_WADDR));
  assign wr_data  = we_i && !busy && (addr_i == HOST_AW'(HOFS_DATA));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      ack_q  <= 1'b0;
      done_q <= 1'b0;
      rnw_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ack_q <= ack_tgl_i;
      if (start_rd || start_wr) begin
        req_q  <= ~req_q;
        done_q <= 1'b0;
        rnw_q  <= start_rd;
        addr_q <= wdata_i[LNK_AW-1:0];
      end else if (ack_edge) begin
        done_q <= 1'b1;
        if (rnw_q) data_q <= lnk_rdata_i;
      end
      if (wr_data) data_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == HOST_AW'(HOFS_DATA)) rdata_o = data_q;
    else if (addr_i == HOST_AW'(HOFS_CTRL)) rdata_o = DW'(done_q);
  end

  assign req_tgl_o    = req_q;
  assign xfer_addr_o  = addr_q;
  assign xfer_wdata_o = data_q;
  assign xfer_rnw_o   = rnw_q;

  p_done_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_rd || start_wr) |=> !done_q);
  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy);
  p_addr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> ($stable(addr_q) && $stable(rnw_q)));
  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !ack_edge) |=> $stable(data_q));
endmodule

// File: rtl/lrb_link_bank.sv
module lrb_link_bank import lrb_pkg::*; #(
  parameter int unsigned DW     = 32,
  parameter int unsigned LNK_AW = 8
) (
  input  logic                         lnk_clk_i,
  input  logic                         lnk_rst_ni,
  input  logic                         req_tgl_i,
  input  logic [LNK_AW-1:0]            addr_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic                         rnw_i,
  input  logic [DW-1:0]                status_i,
  input  logic [DW-1:0]                err_set_i,
  output logic                         ack_tgl_o,
  output logic [DW-1:0]                rdata_o,
  output logic [RW_NUM-1:0][DW-1:0]    rw_o
);
  localparam int unsigned IW = LNK_AW - 2;

  logic            req_q, ack_q, fire, wr_en, hit_stat, hit_err;
  logic [IW-1:0]   idx;
  logic [RW_NUM-1:0] hit_rw;
  logic [DW-1:0]   err_q, rdata_q, rd_val;

  assign idx      = addr_i[LNK_AW-1:2];
  assign fire     = req_tgl_i ^ req_q;
  assign wr_en    = fire && !rnw_i;
  assign hit_stat = idx == IW'(std_byte(STD_STATUS) >> 2);
  assign hit_err  = idx == IW'(std_byte(STD_ERROR) >> 2);

  for (genvar k = 0; k < RW_NUM; k++) begin : g_rw
    logic [DW-1:0] q;
    assign hit_rw[k] = idx == IW'(rw_byte(k) >> 2);
    always_ff @(posedge lnk_clk_i or negedge lnk_rst_ni) begin
      if (!lnk_rst_ni)             q <= '0;
      else if (wr_en && hit_rw[k]) q <= wdata_i;
    end
    assign rw_o[k] = q;
  end

  always_comb begin
    rd_val = '0;
    if (hit_stat) rd_val = status_i;
    if (hit_err)  rd_val = err_q;
    for (int k = 0; k < RW_NUM; k++)
      if (hit_rw[k]) rd_val = rw_o[k];
  end

  always_ff @(posedge lnk_clk_i or negedge lnk_rst_ni) begin
    if (!lnk_rst_ni) begin
      req_q   <= 1'b0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
      err_q   <= '0;
    end else begin
      req_q <= req_tgl_i;
      if (fire) begin
        ack_q <= ~ack_q;
        if (rnw_i) rdata_q <= rd_val;
      end
      // set wins over a same-cycle clear
      err_q <= (err_q & ~((wr_en && hit_err) ? wdata_i : '0)) | err_set_i;
    end
  end

  assign ack_tgl_o = ack_q;
  assign rdata_o   = rdata_q;

  p_single_fire_r9: assert property (@(posedge lnk_clk_i) disable iff (!lnk_rst_ni)
    fire |=> !fire);
  p_rdata_hold_r3: assert property (@(posedge lnk_clk_i) disable iff (!lnk_rst_ni)
    !fire |=> $stable(rdata_q));
  p_err_clear_r8: assert property (@(posedge lnk_clk_i) disable iff (!lnk_rst_ni)
    (wr_en && hit_err && (&wdata_i) && (err_set_i == '0)) |=> (err_q == '0));
endmodule

// File: rtl/link_reg_bridge.sv
module link_reg_bridge import lrb_pkg::*; #(
  parameter int unsigned DW      = 32,
  parameter int unsigned HOST_AW = 5,
  parameter int unsigned LNK_AW  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_we_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [DW-1:0]      host_wdata_i,
  output logic [DW-1:0]      host_rdata_o,
  input  logic               lnk_clk_i,
  input  logic               lnk_rst_ni,
  input  logic [DW-1:0]      lnk_status_i,
  input  logic [DW-1:0]      lnk_err_set_i,
  output logic [DW-1:0]      lnk_ctrl_o,
  output logic [DW-1:0]      lnk_active_o,
  output logic [DW-1:0]      lnk_notify_o,
  output logic [DW-1:0]      lnk_tx_lvl_o,
  output logic [DW-1:0]      lnk_tx_att_o
);
  logic              req_tgl, req_tgl_s, ack_tgl, ack_tgl_s, xfer_rnw;
  logic [LNK_AW-1:0] xfer_addr;
  logic [DW-1:0]     xfer_wdata, lnk_rdata;
  logic [RW_NUM-1:0][DW-1:0] rw;

  lrb_host_port #(.DW(DW), .HOST_AW(HOST_AW), .LNK_AW(LNK_AW)) i_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (host_we_i),
    .addr_i      (host_addr_i),
    .wdata_i     (host_wdata_i),
    .rdata_o     (host_rdata_o),
    .ack_tgl_i   (ack_tgl_s),
    .lnk_rdata_i (lnk_rdata),
    .req_tgl_o   (req_tgl),
    .xfer_addr_o (xfer_addr),
    .xfer_wdata_o(xfer_wdata),
    .xfer_rnw_o  (xfer_rnw)
  );

  lrb_sync #(.W(1)) i_req_sync (
    .clk_i (lnk_clk_i), .rst_ni(lnk_rst_ni), .d_i(req_tgl), .q_o(req_tgl_s)
  );

  lrb_sync #(.W(1)) i_ack_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(ack_tgl), .q_o(ack_tgl_s)
  );

  lrb_link_bank #(.DW(DW), .LNK_AW(LNK_AW)) i_bank (
    .lnk_clk_i (lnk_clk_i),
    .lnk_rst_ni(lnk_rst_ni),
    .req_tgl_i (req_tgl_s),
    .addr_i    (xfer_addr),
    .wdata_i   (xfer_wdata),
    .rnw_i     (xfer_rnw),
    .status_i  (lnk_status_i),
    .err_set_i (lnk_err_set_i),
    .ack_tgl_o (ack_tgl),
    .rdata_o   (lnk_rdata),
    .rw_o      (rw)
  );

  assign lnk_ctrl_o   = rw[0];
  assign lnk_active_o = rw[1];
  assign lnk_notify_o = rw[2];
  assign lnk_tx_lvl_o = rw[3];
  assign lnk_tx_att_o = rw[4];
endmodule

// File: tb/test_link_reg_bridge.sv
`timescale 1ns/1ps
module test_link_reg_bridge;
  logic        clk_i = 0, lnk_clk_i = 0;
  logic        rst_ni = 0, lnk_rst_ni = 0;
  logic        host_we_i = 0;
  logic [4:0]  host_addr_i = '0;
  logic [31:0] host_wdata_i = '0, host_rdata_o;
  logic [31:0] lnk_status_i = '0, lnk_err_set_i = '0;
  logic [31:0] lnk_ctrl_o, lnk_active_o, lnk_notify_o, lnk_tx_lvl_o, lnk_tx_att_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5    clk_i = ~clk_i;
  always #13.3 lnk_clk_i = ~lnk_clk_i;

  link_reg_bridge i_link_reg_bridge (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(int a, logic [31:0] d);
    @(negedge clk_i);
    host_we_i = 1; host_addr_i = 5'(a); host_wdata_i = d;
    @(negedge clk_i);
    host_we_i = 0;
  endtask

  task automatic host_rd(int a, output logic [31:0] d);
    @(negedge clk_i);
    host_addr_i = 5'(a);
    #1 d = host_rdata_o;
  endtask

  task automatic wait_done(output int cyc);
    logic [31:0] v;
    cyc = 0;
    forever begin
      host_rd(31, v);
      if (v[0] || cyc > 300) break;
      cyc++;
    end
    chk("R5 done set", v & 32'h1, 32'h1);
  endtask

  task automatic remote_wr(logic [31:0] a, logic [31:0] d);
    int c;
    host_wr(28, d);
    host_wr(30, a);
    wait_done(c);
  endtask

  task automatic remote_rd(logic [31:0] a, output logic [31:0] d);
    int c;
    host_wr(29, a);
    wait_done(c);
    host_rd(28, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    host_rd(28, v); chk("R1 data word", v, 0);
    host_rd(31, v); chk("R1 control word", v, 0);
    host_rd(29, v); chk("R2 raddr reads 0", v, 0);
    chk("R1 ctrl out", lnk_ctrl_o, 0);
    chk("R1 tx att out", lnk_tx_att_o, 0);
    remote_rd(32'h24, v); chk("R1 error reg", v, 0);
  endtask

  task automatic t_rw_all;
    logic [31:0] v;
    logic [31:0] adr [5] = '{32'h28, 32'h2C, 32'h30, 32'h60, 32'h70};
    for (int k = 0; k < 5; k++) remote_wr(adr[k], 32'h1000_0001 * (k + 3));
    for (int k = 0; k < 5; k++) begin
      remote_rd(adr[k], v);
      chk("R3 R4 read after write", v, 32'h1000_0001 * (k + 3));
    end
    chk("R7 ctrl out", lnk_ctrl_o, 32'h3000_0003);
    chk("R7 active out", lnk_active_o, 32'h4000_0004);
    chk("R7 notify out", lnk_notify_o, 32'h5000_0005);
    chk("R7 tx lvl out", lnk_tx_lvl_o, 32'h6000_0006);
    chk("R7 tx att out", lnk_tx_att_o, 32'h7000_0007);
  endtask

  task automatic t_map_edges;
    logic [31:0] v;
    lnk_status_i = 32'hA5A5_0F0F;
    remote_rd(32'h20, v); chk("R7 status mirror", v, 32'hA5A5_0F0F);
    remote_wr(32'h20, 32'h1234_5678);
    remote_rd(32'h20, v); chk("R7 status read-only", v, 32'hA5A5_0F0F);
    remote_wr(32'h40, 32'hDEAD_BEEF);
    remote_rd(32'h40, v); chk("R7 unmapped reads 0", v, 0);
    remote_rd(32'h2B, v); chk("R7 low addr bits ignored", v, 32'h3000_0003);
    host_wr(5, 32'hFFFF_FFFF);
    host_rd(5, v); chk("R2 other offset reads 0", v, 0);
    host_rd(28, v); chk("R2 data unaffected", v, 32'h3000_0003);
  endtask

  task automatic t_error;
    logic [31:0] v;
    @(negedge lnk_clk_i) lnk_err_set_i = 32'h0000_0105;
    @(negedge lnk_clk_i) lnk_err_set_i = '0;
    remote_rd(32'h24, v); chk("R8 error latched", v, 32'h0000_0105);
    remote_wr(32'h24, 32'h1);
    remote_rd(32'h24, v); chk("R8 partial clear", v, 32'h0000_0104);
    remote_wr(32'h24, 32'hFFFF_FFFF);
    remote_rd(32'h24, v); chk("R8 clear all", v, 0);
  endtask

  task automatic t_done_and_latency;
    logic [31:0] v;
    int c;
    host_wr(29, 32'h2C);
    host_rd(31, v); chk("R5 done cleared on start", v & 32'h1, 0);
    wait_done(c);
    chk("R9 crossing latency", 32'(c >= 4), 1);
    host_rd(28, v); chk("R3 read data", v, 32'h4000_0004);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v;
    int c;
    host_wr(28, 32'hCAFE_0001);
    host_wr(30, 32'h28);
    host_wr(28, 32'hBAD0_BAD0);
    host_wr(30, 32'h70);
    wait_done(c);
    host_rd(28, v); chk("R6 data write ignored", v, 32'hCAFE_0001);
    chk("R6 write used held data", lnk_ctrl_o, 32'hCAFE_0001);
    remote_rd(32'h70, v); chk("R6 second request ignored", v, 32'h7000_0007);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #40 rst_ni = 1; lnk_rst_ni = 1;
    t_reset;
    t_rw_all;
    t_map_edges;
    t_error;
    t_done_and_latency;
    t_busy_ignore;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule